// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block sits between two 16-bit buses, an A side and a B side, and passes data between them in either direction through a bank of level-sensitive storage. One bank takes data from the A side and presents it to the B side. The other bank takes data from the B side and presents it to the A side. Because the two banks are kept apart, a word can travel in one direction while a word stored earlier waits to go the other way.

Each 8-bit byte lane has its own three active-low controls for each direction: a chip enable, a latch enable and an output enable. While both the chip enable and the latch enable of a lane are low, the lane is transparent. The output follows the input in the same cycle, and the storage takes a copy at every rising clock edge. Once either enable goes high, the lane holds the copy taken at the last edge. An output is driven only while both the chip enable and the output enable of its lane are low. To use the block as one 16-bit transceiver, tie the two byte control sets together.

Pads are not modelled here. Each port appears as an input vector, an output vector and a per-bit drive-enable vector, and a pad wrapper builds the tri-state buffers from these three. The latch is emulated in synchronous logic. The stored copy lives in flip-flops that load on the rising clock edge while the lane is transparent. A synchronous active-low reset clears every stored copy to zero.

Top module: `dual_latch_xcvr`

## Requirements
- R1: The A-to-B bank stores A-port data and presents it on the B port, and the B-to-A bank stores B-port data and presents it on the A port. The two banks operate at the same time without affecting each other.
- R2: While a lane's chip enable is high, that lane's storage keeps its value and its output drive enables are all 0, whatever the latch enable and output enable are doing.
- R3: While a lane's latch enable is high, that lane's storage keeps its value and its output shows the stored value.
- R4: While a lane's chip enable and latch enable are both low, the lane is transparent. Its output equals its input in the same cycle, and the storage loads the input at every rising clock edge.
- R5: When a lane leaves transparency, it keeps the input sampled at the last rising edge during which it was transparent. An input change made in the same cycle as the enable rise is not captured.
- R6: While a lane's output enable is high, all of that lane's output drive enables are 0.
- R7: While a lane's chip enable and output enable are both low, all 8 drive enables of that lane are 1.
- R8: The B-to-A direction follows R2 to R7, using its own three controls and driving the A port.
- R9: Control index 0 governs bits 7:0 and index 1 governs bits 15:8. Each byte lane behaves independently of the other.
- R10: Synchronous active-low reset clears all stored values to zero.
- R11: The output vector always carries the lane's latch output, even while its drive enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which the stored copies load |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | Data read from the A-side pads |
| b_in | input | 16 | Data read from the B-side pads |
| ab_ce_n | input | 2 | A-to-B chip enable per byte, active low |
| ab_le_n | input | 2 | A-to-B latch enable per byte, active low |
| ab_oe_n | input | 2 | A-to-B output enable per byte, active low |
| ba_ce_n | input | 2 | B-to-A chip enable per byte, active low |
| ba_le_n | input | 2 | B-to-A latch enable per byte, active low |
| ba_oe_n | input | 2 | B-to-A output enable per byte, active low |
| a_out | output | 16 | Data for the A-side pads (B-to-A latch output) |
| a_oe | output | 16 | Per-bit drive enable for the A-side pads |
| b_out | output | 16 | Data for the B-side pads (A-to-B latch output) |
| b_oe | output | 16 | Per-bit drive enable for the B-side pads |

## Verification
The hardest case to reach is the boundary of R5. There, the latch enable rises and the input changes in the same cycle, and the stored value must be the earlier word and not the new one. The bench sets up transparency, lets one edge pass, and then changes the data and raises the enable together on the falling edge. After that it reads back through an enabled output. The other difficult case is mixed per-byte control. In it, one byte of a direction is transparent while the other holds or floats, and the opposite direction runs at the same time. The vector table steps through these mixtures in sequence, so each stored value depends on the vectors before it.

// File: rtl/xcvr_pkg.sv
// Package: shared widths and the per-lane control bundle for the
// dual-direction latched transceiver. Assumes lanes are whole bytes.
package xcvr_pkg;
    localparam int LANE_W  = 8;
    localparam int N_LANES = 2;
    localparam int BUS_W   = LANE_W * N_LANES;

    // Active-low controls of one lane in one direction.
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } lane_ctl_t;
endpackage

// File: rtl/xcvr_latch_lane.sv
// Module: one byte lane of one direction. Emulates a level-sensitive latch.
// The output is the input while transparent and the stored copy otherwise.
// The copy loads at each rising clock edge while transparent.
// Assumes inputs are steady around the clock edge.
module xcvr_latch_lane
    import xcvr_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  lane_ctl_t    ctl,
    output logic [W-1:0] q,
    output logic [W-1:0] q_oe
);
    logic         hold;
    logic         drive;
    logic [W-1:0] store_q;

    // Purpose: the lane holds when either the chip or the latch enable is high.
    always_comb hold = ctl.ce_n | ctl.le_n;

    // Purpose: the pads drive only while chip and output enable are both low.
    always_comb drive = ~ctl.ce_n & ~ctl.oe_n;

    // Purpose: stored copy, cleared by reset, loaded while transparent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (!hold)
            store_q <= d;
    end

    // Purpose: latch output is the flow-through data or the held copy.
    always_comb q = hold ? store_q : d;

    // Purpose: replicate the lane drive enable across all bits.
    always_comb q_oe = {W{drive}};

    // R4: a transparent cycle loads the input seen at that edge
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.ce_n && !ctl.le_n) |=> (store_q == $past(d)));

    // R3: latch enable high keeps the copy
    assert_le_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.le_n |=> $stable(store_q));

    // R2: chip enable high keeps the copy
    assert_ce_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ce_n |=> $stable(store_q));

    // R10: a reset edge leaves the copy at zero
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (store_q == '0));

    // R11: while holding, the output presents the copy
    assert_present_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.le_n |-> (q == store_q));
endmodule

// File: rtl/xcvr_dir_bank.sv
// Module: all byte lanes of one transfer direction. Splits the bus into
// lanes, gives each lane its own control bundle and reassembles the outputs.
// Assumes control index i governs bits [i*LW +: LW].
module xcvr_dir_bank
    import xcvr_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = N_LANES,
    localparam int BW = LW * NL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] d,
    input  logic [NL-1:0] ce_n,
    input  logic [NL-1:0] le_n,
    input  logic [NL-1:0] oe_n,
    output logic [BW-1:0] q,
    output logic [BW-1:0] q_oe
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        lane_ctl_t ctl;

        // Purpose: gather this lane's three controls into one bundle.
        always_comb ctl = '{ce_n: ce_n[i], le_n: le_n[i], oe_n: oe_n[i]};

        xcvr_latch_lane #(.W(LW)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (d[i*LW +: LW]),
            .ctl  (ctl),
            .q    (q[i*LW +: LW]),
            .q_oe (q_oe[i*LW +: LW])
        );

        // R2: chip enable high floats every bit of the lane
        assert_ce_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ce_n[i] |-> (q_oe[i*LW +: LW] == '0));

        // R6: output enable high floats every bit of the lane
        assert_oe_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[i] |-> (q_oe[i*LW +: LW] == '0));

        // R7: both enables low drive all bits of the lane
        assert_drive_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_n[i] && !oe_n[i]) |-> ($countones(q_oe[i*LW +: LW]) == LW));

        // R4: transparent lane passes its input straight through
        assert_flow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_n[i] && !le_n[i]) |-> (q[i*LW +: LW] == d[i*LW +: LW]));
    end
endmodule

// File: rtl/dual_latch_xcvr.sv
// Module: top of the dual-direction latched transceiver. Holds one bank for
// A-to-B and one for B-to-A. The pads are left to a wrapper that combines
// each out/oe pair with the matching input vector.
module dual_latch_xcvr
    import xcvr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   a_in,
    input  logic [BUS_W-1:0]   b_in,
    input  logic [N_LANES-1:0] ab_ce_n,
    input  logic [N_LANES-1:0] ab_le_n,
    input  logic [N_LANES-1:0] ab_oe_n,
    input  logic [N_LANES-1:0] ba_ce_n,
    input  logic [N_LANES-1:0] ba_le_n,
    input  logic [N_LANES-1:0] ba_oe_n,
    output logic [BUS_W-1:0]   a_out,
    output logic [BUS_W-1:0]   a_oe,
    output logic [BUS_W-1:0]   b_out,
    output logic [BUS_W-1:0]   b_oe
);
    // A-side data stored for the B port (R1)
    xcvr_dir_bank #(.LW(LANE_W), .NL(N_LANES)) u_ab (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (a_in),
        .ce_n (ab_ce_n),
        .le_n (ab_le_n),
        .oe_n (ab_oe_n),
        .q    (b_out),
        .q_oe (b_oe)
    );

    // B-side data stored for the A port (R1, R8)
    xcvr_dir_bank #(.LW(LANE_W), .NL(N_LANES)) u_ba (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (b_in),
        .ce_n (ba_ce_n),
        .le_n (ba_le_n),
        .oe_n (ba_oe_n),
        .q    (a_out),
        .q_oe (a_oe)
    );

    // R1: a held A-to-B byte is untouched by B-side traffic
    assert_bank_isolation_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le_n[0] && $past(ab_le_n[0]) && rst_n && $past(rst_n))
            |-> $stable(b_out[LANE_W-1:0]));
endmodule

// File: tb/sim_dual_latch_xcvr.sv
// Bench: a vector table walked in order (stored state carries between rows),
// then directed checks for reset and the enable-rise boundary.
module sim_dual_latch_xcvr;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] a_in, b_in;
    logic [1:0]  ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
    logic [15:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_latch_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic [1:0]  abce, able, aboe, bace, bale, baoe;
        logic [15:0] eb;
        logic [1:0]  ebo;
        logic [15:0] ea;
        logic [1:0]  eao;
        logic [7:0]  req;
    } vec_t;

    // Control bit [1] is byte 15:8, bit [0] is byte 7:0.
    localparam vec_t VECS [10] = '{
        // R4 A-to-B transparent; R2 B-to-A disabled shows reset copy
        '{16'h1234, 16'hABCD, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11,
          16'h1234, 2'b11, 16'h0000, 2'b00, 8'd4},
        // R3 A-to-B holds; R8 B-to-A transparent, floated
        '{16'h5678, 16'hABCD, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11,
          16'h1234, 2'b11, 16'hABCD, 2'b00, 8'd3},
        // R11 chip enable high: floated but value still shown; R8 hold+drive
        '{16'h9999, 16'h0F0F, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00,
          16'h1234, 2'b00, 16'hABCD, 2'b11, 8'd11},
        // R9 mixed per-byte control in both directions
        '{16'hCAFE, 16'h5555, 2'b00, 2'b10, 2'b01, 2'b01, 2'b00, 2'b00,
          16'h12FE, 2'b10, 16'h55CD, 2'b10, 8'd9},
        // R3 both directions hold the mixed words
        '{16'h0000, 16'h7777, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00,
          16'h12FE, 2'b11, 16'h55CD, 2'b11, 8'd3},
        // R2 byte1 chip enable high, byte0 latch enable high; R6 on B-to-A
        '{16'h3C3C, 16'h8888, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10,
          16'h12FE, 2'b01, 16'h8888, 2'b01, 8'd2},
        // R1 both banks active together
        '{16'h0001, 16'hFFFF, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00,
          16'h0001, 2'b11, 16'h8888, 2'b11, 8'd1},
        // R2 byte0 chip enable high blocks capture and drive
        '{16'hF0F0, 16'hFFFF, 2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00,
          16'hF001, 2'b10, 16'h8888, 2'b00, 8'd2},
        // R6 output enable high floats; R9 B-to-A split
        '{16'h1111, 16'h2222, 2'b00, 2'b11, 2'b11, 2'b00, 2'b01, 2'b01,
          16'hF001, 2'b00, 16'h2288, 2'b10, 8'd6},
        // R7 both directions drive stored words
        '{16'h1111, 16'h3333, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00,
          16'hF001, 2'b11, 16'h2288, 2'b11, 8'd7}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input int r, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic drive_ctl(input logic [1:0] abce, input logic [1:0] able,
                             input logic [1:0] aboe, input logic [1:0] bace,
                             input logic [1:0] bale, input logic [1:0] baoe);
        ab_ce_n = abce; ab_le_n = able; ab_oe_n = aboe;
        ba_ce_n = bace; ba_le_n = bale; ba_oe_n = baoe;
    endtask

    function automatic logic [15:0] spread(input logic [1:0] e);
        return {{8{e[1]}}, {8{e[0]}}};
    endfunction

    // Purpose: step to the next edge and settle just after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        a_in = 16'h0; b_in = 16'h0;
        drive_ctl(2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        a_in = 16'hDEAD; b_in = 16'hBEEF;
        drive_ctl(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00);
        step();
        // R10 reset leaves zero in both banks, shown through enabled outputs
        chk(b_out, 16'h0000, 10, "reset b_out");
        chk(a_out, 16'h0000, 10, "reset a_out");
        chk(b_oe, 16'hFFFF, 7, "reset b_oe");

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            a_in = VECS[i].a; b_in = VECS[i].b;
            drive_ctl(VECS[i].abce, VECS[i].able, VECS[i].aboe,
                      VECS[i].bace, VECS[i].bale, VECS[i].baoe);
            step();
            chk(b_out, VECS[i].eb, int'(VECS[i].req), $sformatf("vec%0d b_out", i));
            chk(b_oe, spread(VECS[i].ebo), int'(VECS[i].req), $sformatf("vec%0d b_oe", i));
            chk(a_out, VECS[i].ea, int'(VECS[i].req), $sformatf("vec%0d a_out", i));
            chk(a_oe, spread(VECS[i].eao), int'(VECS[i].req), $sformatf("vec%0d a_oe", i));
        end

        // R5 enable rise together with a data change keeps the earlier word
        @(negedge clk);
        a_in = 16'hAAAA;
        drive_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00);
        step();
        chk(b_out, 16'hAAAA, 4, "transparent before rise");
        @(negedge clk);
        a_in = 16'hBBBB;
        ab_le_n = 2'b11;
        #1;
        chk(b_out, 16'hAAAA, 5, "same-cycle change after rise");
        step();
        chk(b_out, 16'hAAAA, 5, "held after rise edge");

        // R10 mid-run reset clears stored words
        @(negedge clk);
        rst_n = 1'b0;
        step();
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk(b_out, 16'h0000, 10, "mid-run reset b_out");
        chk(a_out, 16'h0000, 10, "mid-run reset a_out");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Purpose: end a hung run as a failure.
    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R0 watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule